// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port, byte-wide synchronous memory whose data phase trails its command phase by exactly one enabled clock. The address and the read/write choice are registered on a rising edge. The data for that command moves in the cycle that follows. A read word flows from the array through combinational logic during that next cycle. A write word is taken on the next edge at which the pipeline advances. Because every command's data slot is the cycle after it, reads and writes can follow each other in any order with no idle cycle between them.

The host can freeze the pipeline with an active-low clock enable. It can also stop new commands with an active-low select, which still lets the command already in flight finish. An asynchronous active-low output enable gates the read path. The tri-state bus is split into a write-data input, a read-data output and a drive flag. The address width is a parameter. The default of 10 bits keeps elaboration small, and the full 17-bit, 128K-word organisation is a parameter setting. An optional parameter zero-fills the array at start.

Top module: `zbt_sram`

## Requirements
- R1: While rst_ni is low and after it rises, no command is pending and drive_o is 0; rdata_o reads 0 whenever drive_o is 0.
- R2: A rising edge with cen_ni=0, cs_ni=0 and we_ni=1 starts a read of addr_i. During the following cycle, with oe_ni=0, drive_o is 1 and rdata_o holds the word stored at that address, with no extra register stage.
- R3: A rising edge with cen_ni=0, cs_ni=0 and we_ni=0 starts a write to addr_i. The word on wdata_i at the next rising edge with cen_ni=0 is stored there.
- R4: At an edge with cen_ni=1, all other synchronous inputs are ignored and the pending command is held. A pending read keeps presenting the same word, and a pending write keeps waiting for the next edge with cen_ni=0.
- R5: An edge with cen_ni=0 and cs_ni=1 starts no command, but completes the pending one. In the cycle after it, drive_o is 0.
- R6: oe_ni is asynchronous. While it is 1, drive_o is 0 at once, and lowering it during a pending read raises drive_o within the same cycle.
- R7: Reads and writes may alternate on consecutive enabled edges with no dead cycle. A read issued on the edge right after a write to the same address returns the newly written word.
- R8: we_ni has no effect at any edge where cs_ni or cen_ni is 1; no array location changes because of it.
- R9: While the pending command is a write, drive_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low; high freezes the pipeline |
| cs_ni | input | 1 | Select, active low; high starts no command |
| we_ni | input | 1 | Write enable, active low; high selects a read |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data, sampled one enabled edge after its command |
| rdata_o | output | DATA_W | Read data, valid while drive_o is 1, otherwise 0 |
| drive_o | output | 1 | Bus drive flag, standing in for tri-state control |

## Verification
At a single enabled edge, the write data of the previous command is committed to the array, and at the same edge a new read command may be captured for that very address. The bench provokes this by pairing each write with a read of the same address on the next edge, across the whole address range. It then checks that the flow-through read presents the new word. Random stalls and deselects are laid over such streams, so that a held write meets a fresh read, and every cycle is judged against a bench model of the array and the pending command.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;
endpackage

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pend_vld_o,
  output op_e               pend_op_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic              commit_o
);
  logic advance;
  logic start;

  assign advance = ~cen_ni;
  assign start   = advance & ~cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_o  <= 1'b0;
      pend_op_o   <= OP_RD;
      pend_addr_o <= '0;
    end else if (advance) begin
      pend_vld_o <= start;
      if (start) begin
        pend_op_o   <= we_ni ? OP_RD : OP_WR;
        pend_addr_o <= addr_i;
      end
    end
  end

  // a pending write lands on the edge where the pipe moves on
  assign commit_o = advance & pend_vld_o & (pend_op_o == OP_WR);
endmodule

// File: rtl/zbt_sram_array.sv
module zbt_sram_array #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter bit INIT_ZERO = 1'b1
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  generate
    if (INIT_ZERO) begin : g_zero
      initial begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // flow-through: no output register
  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/zbt_sram_outgate.sv
module zbt_sram_outgate
  import zbt_sram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              pend_vld_i,
  input  op_e               pend_op_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic rd_active;

  assign rd_active = pend_vld_i & (pend_op_i == OP_RD);
  assign drive_o   = rd_active & ~oe_ni;
  assign rdata_o   = drive_o ? word_i : '0;
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter bit INIT_ZERO = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              pend_vld;
  op_e               pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic              commit;
  logic [DATA_W-1:0] arr_word;
  logic              pend_wr;

  assign pend_wr = (pend_op == OP_WR);

  zbt_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cen_ni     (cen_ni),
    .cs_ni      (cs_ni),
    .we_ni      (we_ni),
    .addr_i     (addr_i),
    .pend_vld_o (pend_vld),
    .pend_op_o  (pend_op),
    .pend_addr_o(pend_addr),
    .commit_o   (commit)
  );

  zbt_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_ZERO(INIT_ZERO)) u_array (
    .clk_i    (clk_i),
    .wr_en_i  (commit),
    .wr_addr_i(pend_addr),
    .wr_data_i(wdata_i),
    .rd_addr_i(pend_addr),
    .rd_data_o(arr_word)
  );

  zbt_sram_outgate #(.DATA_W(DATA_W)) u_gate (
    .pend_vld_i(pend_vld),
    .pend_op_i (pend_op),
    .oe_ni     (oe_ni),
    .word_i    (arr_word),
    .rdata_o   (rdata_o),
    .drive_o   (drive_o)
  );
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              cs_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o,
  input logic              pend_vld,
  input logic              pend_wr,
  input logic [ADDR_W-1:0] pend_addr
);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!pend_vld && !drive_o));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && !cs_ni) |=>
      (pend_vld && pend_addr == $past(addr_i) && pend_wr == !$past(we_ni)));

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(pend_vld) && $stable(pend_wr) && $stable(pend_addr)));

  assert_stall_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(oe_ni) -> $stable(rdata_o)));

  assert_deselect_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_ni && cs_ni) |=> (!pend_vld && !drive_o));

  assert_oe_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);

  assert_quiet_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (rdata_o == '0));

  assert_write_no_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld && pend_wr) |-> !drive_o);
endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cen_ni = 1'b1;
  logic          cs_ni = 1'b1;
  logic          we_ni = 1'b1;
  logic          oe_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic          m_vld = 1'b0;
  logic          m_wr = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #2.5 clk_i = ~clk_i;

  zbt_sram #(.ADDR_W(AW), .DATA_W(DW), .INIT_ZERO(1'b1)) u_zbt_sram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cen_ni (cen_ni),
    .cs_ni  (cs_ni),
    .we_ni  (we_ni),
    .oe_ni  (oe_ni),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .drive_o(drive_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] got_d, input logic got_o,
                       input logic [DW-1:0] exp_d, input logic exp_o);
    n_run++;
    if (got_d !== exp_d || got_o !== exp_o) begin
      n_fail++;
      $display("FAIL %s: rdata=%0h drive=%0b expected rdata=%0h drive=%0b",
               tag, got_d, got_o, exp_d, exp_o);
    end
  endtask

  task automatic check_model(input string tag);
    logic          e_o;
    logic [DW-1:0] e_d;
    e_o = m_vld && !m_wr && !oe_ni;
    e_d = e_o ? m_mem[m_addr] : '0;
    check(tag, rdata_o, drive_o, e_d, e_o);
  endtask

  // drive at negedge, check mid-cycle, then clock the model
  task automatic step(input string tag, input logic cen, input logic cs, input logic we,
                      input logic oe, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    cen_ni = cen; cs_ni = cs; we_ni = we; oe_ni = oe; addr_i = a; wdata_i = d;
    #1;
    check_model(tag);
    @(posedge clk_i);
    if (!cen) begin
      if (m_vld && m_wr) m_mem[m_addr] = d;
      m_vld  = !cs;
      m_wr   = !we;
      m_addr = a;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    #7;
    check("R1", rdata_o, drive_o, '0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    oe_ni  = 1'b0;
    #1;
    check("R1", rdata_o, drive_o, '0, 1'b0);

    // R3: write sweep, back to back
    for (int a = 0; a < DEPTH; a++)
      step("R3", 1'b0, 1'b0, 1'b0, 1'b0, a[AW-1:0], 8'(a * 37 + 5));
    // R2: read sweep, back to back
    for (int a = 0; a < DEPTH; a++)
      step("R2", 1'b0, 1'b0, 1'b1, 1'b0, a[AW-1:0], 8'hee);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, '0, 8'h00);
    step("R5", 1'b0, 1'b1, 1'b1, 1'b0, '0, 8'h00);

    // R7: write then read same address on the next edge
    for (int a = 0; a < DEPTH; a++) begin
      step("R7", 1'b0, 1'b0, 1'b0, 1'b0, a[AW-1:0], 8'hff);
      step("R7", 1'b0, 1'b0, 1'b1, 1'b0, a[AW-1:0], 8'(a ^ 8'h5a));
    end
    step("R7", 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 8'h00);

    // R8: we low while deselected or stalled, then read back
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 8'h11);
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 4'd7, 8'h22);
    step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 4'd8, 8'h33);
    step("R8", 1'b0, 1'b0, 1'b1, 1'b0, 4'd6, 8'h44);
    step("R8", 1'b0, 1'b0, 1'b1, 1'b0, 4'd7, 8'h55);
    step("R8", 1'b0, 1'b0, 1'b1, 1'b0, 4'd8, 8'h66);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00);

    // R4: stalled write keeps waiting, stalled read holds
    step("R4", 1'b0, 1'b0, 1'b0, 1'b0, 4'd9, 8'h01);
    step("R9", 1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 8'h02);
    step("R9", 1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 8'h03);
    step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 4'd9, 8'hc4);
    step("R4", 1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 8'h05);
    step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 8'h06);
    step("R4", 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00);

    // R6: oe toggled inside a read cycle
    step("R6", 1'b0, 1'b0, 1'b1, 1'b0, 4'd9, 8'h00);
    @(negedge clk_i);
    cen_ni = 1'b1;
    oe_ni = 1'b1; #0.5;
    check("R6", rdata_o, drive_o, '0, 1'b0);
    oe_ni = 1'b0; #0.5;
    check("R6", rdata_o, drive_o, m_mem[9], 1'b1);

    // random mix of reads, writes, stalls, deselects and oe
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      step("R4", r < 20, (r % 7) == 0, $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
           AW'($urandom_range(0, DEPTH - 1)), 8'($urandom_range(0, 255)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule